// File: doc/BRIEF.md
# SPI Flash Command Engine

This block runs a single serial-flash transaction on demand. Software loads a command word (command byte plus a 24-bit flash address) and, when needed, a data word, then writes the control word with the start bit set. The control word also carries the number of bytes to send and the number of bytes to receive. The engine lowers chip select and shifts the outgoing bytes out in SPI mode 0. It takes them from the command word first and then from the data word. It then clocks in the requested number of reply bytes and places them in the data word, starting at the low byte.

A busy flag in the control word stays high from the start until chip select is released. Software polls this flag and then reads the reply from the data register. Two small fields in the control word act as plain read/write storage for neighbouring logic, and no transaction changes them. The SPI clock runs at the system clock divided by twice the `CLK_DIV` parameter.

Top module: `spi_cmd_engine`

## Requirements
- R1: Registers are word-aligned: 0x0 control, 0x4 command word, 0x8 data word. Other addresses read 0 and ignore writes. Control reads back transmit count in [3:0], receive count in [7:4] and busy in [16]. Bit [8] (start) always reads 0. The unlisted bits read 0.
- R2: A transmit count above 8 is stored as 8, and a receive count above 4 is stored as 4.
- R3: A control write with bit [8] set, a nonzero transmit count and no transaction running lowers `spi_cs_n` at the next clock edge.
- R4: Outgoing byte order is fixed. First the command byte (command word [7:0]). Then the address high to low (command word [31:24], [23:16], [15:8]). Then data word [7:0], [15:8], [23:16], [31:24]. Only the first "transmit count" bytes are sent, each MSB first. `spi_mosi` is low during the receive phase.
- R5: SPI mode 0 is used. `spi_sck` idles low and each half period lasts `CLK_DIV` clocks. A transaction has exactly 8×(transmit + receive) rising edges.
- R6: Reply byte k (k = 0 first) is sampled MSB first on rising `spi_sck` and written to data word bits [8k+7:8k]. Data bytes at or above the receive count keep their value.
- R7: `spi_cs_n` stays low for (transmit + receive)×16×`CLK_DIV` + 2×`CLK_DIV` clocks. That is the bits plus one SCK period after the last bit. The busy bit reads 1 exactly while `spi_cs_n` is low.
- R8: Any register write while busy, including a new start, has no effect.
- R9: A start with transmit count 0 never lowers `spi_cs_n`, never sets busy and leaves the data word unchanged.
- R10: Control bits [25:24] and [18:17] are stored on a control write, read back unchanged and are not altered by a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| spi_sck | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench builds the engine with `CLK_DIV` = 2, so each bit takes four clocks. Even the longest 12-byte transaction then finishes in a few hundred cycles, and chip-select lengths can be compared exactly.

A behavioural flash model drives a reply pattern and records every bit sent. This lets the bench check each transmit count from 1 to 8 and each receive count from 0 to 4. It also covers the clamp limits, a zero-length start, and writes issued in the middle of a transaction.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int REG_W      = 32;
    localparam int REG_ADDR_W = 4;
    localparam int CNT_W      = 4;
    localparam int MAX_TX     = 8;
    localparam int MAX_RX     = 4;
    localparam int TX_VEC_W   = MAX_TX * 8;
    localparam int BIT_W      = $clog2((MAX_TX + MAX_RX) * 8 + 1);
    localparam int RXP_W      = $clog2(MAX_RX * 8);
    localparam int RXI_W      = $clog2(MAX_RX);

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_SHIFT = 2'd1,
        SH_TAIL  = 2'd2
    } sh_state_e;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [1:0]       clk_sel;
        logic [1:0]       size_f;
        logic [CNT_W-1:0] rx_cnt;
        logic [CNT_W-1:0] tx_cnt;
    } ctrl_s;

    typedef struct packed {
        logic             go;
        logic [CNT_W-1:0] tx;
        logic [CNT_W-1:0] rx;
    } launch_s;

    function automatic logic [CNT_W-1:0] clamp_cnt(logic [CNT_W-1:0] v, int lim);
        return (v > CNT_W'(lim)) ? CNT_W'(lim) : v;
    endfunction

    // Command byte, address high to low, then data word low byte first.
    function automatic logic [TX_VEC_W-1:0] pack_tx(logic [REG_W-1:0] cmd, logic [REG_W-1:0] dat);
        return {cmd[7:0], cmd[31:24], cmd[23:16], cmd[15:8],
                dat[7:0], dat[15:8], dat[23:16], dat[31:24]};
    endfunction

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]      wdata,
    input  logic                  busy,
    input  logic                  rx_we,
    input  logic [RXI_W-1:0]      rx_idx,
    input  logic [7:0]            rx_byte,
    output logic [REG_W-1:0]      rdata,
    output ctrl_s                 ctrl_q,
    output logic [REG_W-1:0]      cmd_q,
    output logic [REG_W-1:0]      dat_q,
    output launch_s               launch
);

    reg_sel_e         sel;
    logic             wr_ok;
    logic [CNT_W-1:0] tx_new;
    logic [CNT_W-1:0] rx_new;

    assign sel    = (addr[1:0] == 2'b00) ? reg_sel_e'(addr[3:2]) : SEL_NONE;
    assign wr_ok  = wr && !busy;
    assign tx_new = clamp_cnt(wdata[3:0], MAX_TX);
    assign rx_new = clamp_cnt(wdata[7:4], MAX_RX);

    always_comb begin
        launch.go = wr_ok && (sel == SEL_CTRL) && wdata[8] && (tx_new != '0);
        launch.tx = tx_new;
        launch.rx = rx_new;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cmd_q  <= '0;
            dat_q  <= '0;
        end else begin
            if (wr_ok && sel == SEL_CTRL) begin
                ctrl_q.clk_sel <= wdata[25:24];
                ctrl_q.size_f  <= wdata[18:17];
                ctrl_q.rx_cnt  <= rx_new;
                ctrl_q.tx_cnt  <= tx_new;
            end
            if (wr_ok && sel == SEL_CMD)  cmd_q <= wdata;
            if (wr_ok && sel == SEL_DATA) dat_q <= wdata;
            if (rx_we) dat_q[{rx_idx, 3'b000} +: 8] <= rx_byte;
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CTRL: begin
                rdata[3:0]   = ctrl_q.tx_cnt;
                rdata[7:4]   = ctrl_q.rx_cnt;
                rdata[16]    = busy;
                rdata[18:17] = ctrl_q.size_f;
                rdata[25:24] = ctrl_q.clk_sel;
            end
            SEL_CMD:  rdata = cmd_q;
            SEL_DATA: rdata = dat_q;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
    import spi_cmd_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  launch_s          launch,
    input  logic [REG_W-1:0] cmd,
    input  logic [REG_W-1:0] dat,
    input  logic             miso,
    output logic             busy,
    output logic             sck,
    output logic             mosi,
    output logic             rx_we,
    output logic [RXI_W-1:0] rx_idx,
    output logic [7:0]       rx_byte
);

    localparam int DIV_W = (2 * CLK_DIV > 1) ? $clog2(2 * CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] HALF_LD = DIV_W'(CLK_DIV - 1);
    localparam logic [DIV_W-1:0] TAIL_LD = DIV_W'(2 * CLK_DIV - 1);

    sh_state_e           st;
    logic [DIV_W-1:0]    div;
    logic [TX_VEC_W-1:0] tx_sr;
    logic [BIT_W-1:0]    bit_idx;
    logic [BIT_W-1:0]    tx_bits;
    logic [BIT_W-1:0]    last_bit;
    logic [6:0]          rx_acc;
    logic                tick;
    logic                in_rx;
    logic [RXP_W-1:0]    rx_pos;

    assign tick    = (div == '0);
    assign in_rx   = (bit_idx >= tx_bits);
    assign rx_pos  = RXP_W'(bit_idx - tx_bits);
    assign busy    = (st != SH_IDLE);
    assign mosi    = (st == SH_SHIFT) && !in_rx && tx_sr[TX_VEC_W-1];
    assign rx_we   = (st == SH_SHIFT) && tick && !sck && in_rx && (rx_pos[2:0] == 3'd7);
    assign rx_idx  = rx_pos[RXP_W-1:3];
    assign rx_byte = {rx_acc, miso};

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SH_IDLE;
            div      <= '0;
            sck      <= 1'b0;
            tx_sr    <= '0;
            bit_idx  <= '0;
            tx_bits  <= '0;
            last_bit <= '0;
            rx_acc   <= '0;
        end else begin
            case (st)
                SH_IDLE: begin
                    if (launch.go) begin
                        st       <= SH_SHIFT;
                        div      <= HALF_LD;
                        sck      <= 1'b0;
                        tx_sr    <= pack_tx(cmd, dat);
                        bit_idx  <= '0;
                        tx_bits  <= BIT_W'({launch.tx, 3'b000});
                        last_bit <= BIT_W'({launch.tx, 3'b000}) + BIT_W'({launch.rx, 3'b000}) - 1'b1;
                    end
                end
                SH_SHIFT: begin
                    if (!tick) begin
                        div <= div - 1'b1;
                    end else if (!sck) begin
                        sck <= 1'b1;
                        div <= HALF_LD;
                        if (in_rx) rx_acc <= {rx_acc[5:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bit_idx == last_bit) begin
                            st  <= SH_TAIL;
                            div <= TAIL_LD;
                        end else begin
                            div     <= HALF_LD;
                            bit_idx <= bit_idx + 1'b1;
                            tx_sr   <= {tx_sr[TX_VEC_W-2:0], 1'b0};
                        end
                    end
                end
                SH_TAIL: begin
                    if (!tick) div <= div - 1'b1;
                    else       st  <= SH_IDLE;
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output logic                  spi_sck,
    output logic                  spi_cs_n,
    output logic                  spi_mosi,
    input  logic                  spi_miso
);

    logic             busy;
    ctrl_s            ctrl_q;
    logic [REG_W-1:0] cmd_q;
    logic [REG_W-1:0] dat_q;
    launch_s          launch;
    logic             rx_we;
    logic [RXI_W-1:0] rx_idx;
    logic [7:0]       rx_byte;

    spi_cmd_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .busy   (busy),
        .rx_we  (rx_we),
        .rx_idx (rx_idx),
        .rx_byte(rx_byte),
        .rdata  (reg_rdata),
        .ctrl_q (ctrl_q),
        .cmd_q  (cmd_q),
        .dat_q  (dat_q),
        .launch (launch)
    );

    spi_cmd_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .cmd    (cmd_q),
        .dat    (dat_q),
        .miso   (spi_miso),
        .busy   (busy),
        .sck    (spi_sck),
        .mosi   (spi_mosi),
        .rx_we  (rx_we),
        .rx_idx (rx_idx),
        .rx_byte(rx_byte)
    );

    assign spi_cs_n = !busy;

endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [3:0]  reg_addr,
    input logic        wd_start,
    input logic [3:0]  wd_tx,
    input logic        rd_busy,
    input logic        rd_start,
    input logic [7:0]  rd_cnts,
    input logic        spi_sck,
    input logic        spi_cs_n,
    input logic [31:0] cmd_q
);

    logic ctrl_sel;
    assign ctrl_sel = (reg_addr == 4'h0);

    // R3: a valid start lowers chip select one edge later
    p_launch_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && ctrl_sel && wd_start && wd_tx != 4'd0 && spi_cs_n) |=> !spi_cs_n);

    // R9: zero-length start leaves chip select high
    p_zero_tx_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && ctrl_sel && wd_start && wd_tx == 4'd0 && spi_cs_n) |=> spi_cs_n);

    // R5: clock idles low whenever the flash is deselected
    p_sck_idle_r5: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    // R7: busy flag mirrors chip select
    p_busy_flag_r7: assert property (@(posedge clk) disable iff (rst)
        ctrl_sel |-> (rd_busy == !spi_cs_n));

    // R2: stored counts never exceed limits
    p_clamp_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl_sel |-> (rd_cnts[3:0] <= 4'd8 && rd_cnts[7:4] <= 4'd4));

    // R1: start bit never reads back as set
    p_start_rd_r1: assert property (@(posedge clk) disable iff (rst)
        ctrl_sel |-> !rd_start);

    // R8: command word is frozen while busy
    p_cmd_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && reg_wr && reg_addr == 4'h4) |=> $stable(cmd_q));

endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .reg_wr  (reg_wr),
    .reg_addr(reg_addr),
    .wd_start(reg_wdata[8]),
    .wd_tx   (reg_wdata[3:0]),
    .rd_busy (reg_rdata[16]),
    .rd_start(reg_rdata[8]),
    .rd_cnts (reg_rdata[7:0]),
    .spi_sck (spi_sck),
    .spi_cs_n(spi_cs_n),
    .cmd_q   (cmd_q)
);

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;

    localparam int BENCH_DIV = 2;

    typedef struct packed {
        logic [3:0]  tx;
        logic [3:0]  rx;
        logic [31:0] cmd;
        logic [31:0] dat;
        logic [31:0] resp;
    } vec_t;

    localparam vec_t VECS [0:6] = '{
        '{4'd1, 4'd0, 32'h0000_0006, 32'h1122_3344, 32'h0000_0000},
        '{4'd1, 4'd1, 32'h0000_0005, 32'hA5A5_A5A5, 32'h0000_00C3},
        '{4'd4, 4'd0, 32'h1234_56D8, 32'h0BAD_F00D, 32'h0000_0000},
        '{4'd5, 4'd0, 32'hABCD_EF0B, 32'h5A5A_5AF0, 32'h0000_0000},
        '{4'd8, 4'd0, 32'h0010_0002, 32'hDEAD_BEEF, 32'h0000_0000},
        '{4'd4, 4'd4, 32'h0002_0003, 32'h0000_0000, 32'h8765_4321},
        '{4'd2, 4'd3, 32'h0000_FF9F, 32'hFFFF_FFFF, 32'h00E1_B2C4}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // flash model state
    logic [95:0] miso_pat = '0;
    int          mdl_cnt = 0;
    logic [95:0] cap = '0;
    int          cap_n = 0;
    int          cs_cyc = 0;
    int          cs_falls = 0;
    logic        cs_prev = 1'b1;

    always #10 clk = ~clk;

    spi_cmd_engine #(.CLK_DIV(BENCH_DIV)) u_spi_cmd_engine (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always @(negedge spi_sck or posedge spi_cs_n) begin
        if (spi_cs_n) mdl_cnt <= 0;
        else          mdl_cnt <= mdl_cnt + 1;
    end
    assign spi_miso = (!spi_cs_n && mdl_cnt < 96) ? miso_pat[95 - mdl_cnt] : 1'b0;

    always @(negedge spi_cs_n or posedge spi_sck) begin
        if (!spi_sck) begin
            cap   <= '0;
            cap_n <= 0;
        end else if (!spi_cs_n) begin
            cap   <= {cap[94:0], spi_mosi};
            cap_n <= cap_n + 1;
        end
    end

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        cs_prev <= spi_cs_n;
        if (cs_prev && !spi_cs_n) cs_falls <= cs_falls + 1;
        if (!spi_cs_n) cs_cyc <= cs_prev ? 1 : cs_cyc + 1;
    end

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 4000; i++) begin
            rd(4'h0, v);
            if (!v[16]) break;
        end
    endtask

    function automatic logic [95:0] exp_stream(input vec_t v);
        logic [7:0]  b [0:7];
        logic [95:0] s;
        b[0] = v.cmd[7:0];   b[1] = v.cmd[31:24]; b[2] = v.cmd[23:16]; b[3] = v.cmd[15:8];
        b[4] = v.dat[7:0];   b[5] = v.dat[15:8];  b[6] = v.dat[23:16]; b[7] = v.dat[31:24];
        s = '0;
        for (int i = 0; i < int'(v.tx); i++) s = {s[87:0], b[i]};
        for (int k = 0; k < int'(v.rx); k++) s = {s[87:0], 8'h00};
        return s;
    endfunction

    initial begin
        logic [31:0] r;
        logic [31:0] expd;
        int          falls0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R5: reset state
        rd(4'h0, r); chk("R1 reset control", r, 0);
        rd(4'h4, r); chk("R1 reset command", r, 0);
        rd(4'h8, r); chk("R1 reset data", r, 0);
        chk("R5 reset cs_n/sck", {spi_cs_n, spi_sck}, 2'b10);

        // R1: unmapped address
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, r); chk("R1 unmapped reads 0", r, 0);

        // vector table
        for (int vi = 0; vi < 7; vi++) begin
            vec_t v;
            int   nb;
            v  = VECS[vi];
            nb = (int'(v.tx) + int'(v.rx)) * 8;
            miso_pat = '0;
            for (int k = 0; k < int'(v.rx); k++)
                miso_pat[95 - 8 * (int'(v.tx) + k) -: 8] = v.resp[8 * k +: 8];
            wr(4'h8, v.dat);
            wr(4'h4, v.cmd);
            rd(4'h4, r); chk($sformatf("R1 vec%0d command readback", vi), r, v.cmd);
            wr(4'h0, {23'd0, 1'b1, v.rx, v.tx});
            wait_idle();
            chk($sformatf("R5 vec%0d rising edges", vi), cap_n, nb);
            chk($sformatf("R4 vec%0d mosi stream", vi), cap, exp_stream(v));
            expd = v.dat;
            for (int k = 0; k < int'(v.rx); k++) expd[8 * k +: 8] = v.resp[8 * k +: 8];
            rd(4'h8, r); chk($sformatf("R6 vec%0d data word", vi), r, expd);
            chk($sformatf("R7 vec%0d cs low cycles", vi), cs_cyc, nb * 2 * BENCH_DIV + 2 * BENCH_DIV);
        end

        // R2: clamping
        wr(4'h0, 32'h0000_00FF);
        rd(4'h0, r); chk("R2 clamp to 8/4", r[7:0], 8'h48);

        // R10 + R7 busy readback: preserved fields
        miso_pat = '0;
        wr(4'h0, 32'h0202_0101);
        rd(4'h0, r); chk("R7 busy bit while running", r, 32'h0203_0001);
        wait_idle();
        rd(4'h0, r); chk("R10 preserved fields", r, 32'h0202_0001);

        // R8 / R3: writes during a transaction are ignored
        wr(4'h8, 32'h0000_0000);
        wr(4'h4, 32'h0000_00D8);
        wr(4'h0, 32'h0000_0104);
        chk("R3 cs_n low after start", spi_cs_n, 1'b0);
        wr(4'h0, 32'h0000_0148);
        wr(4'h8, 32'hCAFE_F00D);
        wr(4'h4, 32'h7777_7777);
        wait_idle();
        rd(4'h0, r); chk("R8 control unchanged", r, 32'h0000_0004);
        rd(4'h8, r); chk("R8 data unchanged", r, 32'h0000_0000);
        rd(4'h4, r); chk("R8 command unchanged", r, 32'h0000_00D8);
        chk("R8 length unchanged", cs_cyc, 32 * 2 * BENCH_DIV + 2 * BENCH_DIV);

        // R9: zero transmit count
        wr(4'h8, 32'h1357_9BDF);
        falls0 = cs_falls;
        wr(4'h0, 32'h0000_0130);
        repeat (20) @(negedge clk);
        chk("R9 no chip select", cs_falls, falls0);
        rd(4'h0, r); chk("R9 not busy", r[16], 1'b0);
        rd(4'h8, r); chk("R9 data unchanged", r, 32'h1357_9BDF);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait (cyc >= 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R7 transaction never finished actual=%0d expected<100000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule